// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned 32-bit operands into a 64-bit result over a fixed number of clock cycles. It uses one adder as wide as an operand, a register that holds the multiplicand, and a double-width product register. The multiplier has no register of its own. It is placed in the low half of the product register and shifted out one bit per cycle, while partial sums build up in the high half.

A caller raises the start input with both operands present. The block loads its registers on that edge and holds busy high while it iterates. It then pulses done for one cycle, and the full product stays on the output until the next accepted start. Signed operands must be converted to magnitudes before they reach the block.

Top module: `shift_add_mul`

## Requirements
- R1: After reset, busyOut and doneOut are 0 and productOut is 0.
- R2: When startIn is sampled high while busyOut is 0, busyOut is 1 after that edge. productOut then shows zero in bits 63:32 and the multiplier operand in bits 31:0.
- R3: The final productOut equals the exact unsigned 64-bit product of the two operands captured at the accepted start.
- R4: doneOut rises on the 32nd clock edge after the edge that accepted the start, and busyOut stays 1 during every cycle in between.
- R5: doneOut stays high for exactly one cycle, and busyOut is 0 whenever doneOut is 1.
- R6: While busyOut is 1, startIn and changes on the operand inputs have no effect on the result or on the timing of doneOut.
- R7: After doneOut, productOut holds its value and doneOut stays 0 until another start is accepted.
- R8: A start accepted in the cycle doneOut is high, or at any later time, reloads the registers and produces the new product with the same latency.
- R9: Zero and all-ones operands still take 32 iterations and give the exact product. For example, 0xFFFFFFFF times 0xFFFFFFFF gives 0xFFFFFFFE00000001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | Request to begin a multiplication; taken only when idle |
| multiplicandIn | input | 32 | Unsigned multiplicand |
| multiplierIn | input | 32 | Unsigned multiplier |
| busyOut | output | 1 | High while iterations are in progress |
| doneOut | output | 1 | One-cycle pulse when the product is complete |
| productOut | output | 64 | Product register contents |

## Verification
If the iteration counter is off by one, doneOut comes one edge early or late. The product is also shifted by one bit, so both the latency check and the value check catch it in the first multiplication. An adder carry dropped out of the 33rd bit changes the top product bits only for operand pairs whose partial sums overflow 32 bits. For that reason the vectors include all-ones and high-bit operands. A load that fails to clear the high half, or a start that leaks in while busy, shows up in the very next product compared against an independently computed value.

// File: rtl/mul_pkg.sv
package mul_pkg;
  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;  // capture operands, clear upper half
    logic step;  // perform one add-and-shift iteration
  } mulStrobes_t;
endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startIn,
  output mulStrobes_t strobes,
  output logic        busyOut,
  output logic        doneOut
);
  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_ITER = CNT_W'(WIDTH - 1);

  logic             busyReg;
  logic             doneReg;
  logic [CNT_W-1:0] iterCount;
  logic             lastStep;

  assign lastStep      = busyReg && (iterCount == LAST_ITER);
  assign strobes.load  = startIn && !busyReg;
  assign strobes.step  = busyReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyReg   <= 1'b0;
      doneReg   <= 1'b0;
      iterCount <= '0;
    end else begin
      doneReg <= lastStep;
      if (strobes.load) begin
        busyReg   <= 1'b1;
        iterCount <= '0;
      end else if (busyReg) begin
        iterCount <= iterCount + 1'b1;
        if (lastStep) busyReg <= 1'b0;
      end
    end
  end

  assign busyOut = busyReg;
  assign doneOut = doneReg;

  // done is a single-cycle pulse and never overlaps busy
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    doneReg |=> !doneReg);
  assert_done_not_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    doneReg |-> !busyReg);
  // done only follows a busy cycle
  assert_done_after_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    doneReg |-> $past(busyReg));
  // a run in progress keeps counting regardless of start
  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busyReg && !lastStep) |=> (busyReg && iterCount == $past(iterCount) + 1'b1));
  // acceptance sets busy
  assert_start_taken_R2: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && !busyReg) |=> (busyReg && iterCount == '0));
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath
  import mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  mulStrobes_t        strobes,
  input  logic [WIDTH-1:0]   multiplicandIn,
  input  logic [WIDTH-1:0]   multiplierIn,
  output logic [2*WIDTH-1:0] productOut
);
  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] mcandReg;
  logic [PW-1:0]    prodReg;
  logic [WIDTH-1:0] addend;
  logic [WIDTH:0]   partialSum;  // carry kept as extra bit

  assign addend     = prodReg[0] ? mcandReg : '0;
  assign partialSum = {1'b0, prodReg[PW-1:WIDTH]} + {1'b0, addend};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcandReg <= '0;
      prodReg  <= '0;
    end else if (strobes.load) begin
      mcandReg <= multiplicandIn;
      prodReg  <= {{WIDTH{1'b0}}, multiplierIn};
    end else if (strobes.step) begin
      // {carry, sum, low half} shifted right by one
      prodReg <= {partialSum, prodReg[WIDTH-1:1]};
    end
  end

  assign productOut = prodReg;

  assert_load_image_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (prodReg[PW-1:WIDTH] == '0 && prodReg[WIDTH-1:0] == $past(multiplierIn)));
  // with no add, the shifted-in top bit must be zero
  assert_noadd_topbit_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && !strobes.load && !prodReg[0]) |=> !prodReg[PW-1]);
  // multiplicand is frozen during a run
  assert_mcand_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && !strobes.load) |=> $stable(mcandReg));
  // idle product holds
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.step && !strobes.load) |=> $stable(prodReg));
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul
  import mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startIn,
  input  logic [WIDTH-1:0]   multiplicandIn,
  input  logic [WIDTH-1:0]   multiplierIn,
  output logic               busyOut,
  output logic               doneOut,
  output logic [2*WIDTH-1:0] productOut
);
  mulStrobes_t strobes;

  mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .strobes (strobes),
    .busyOut (busyOut),
    .doneOut (doneOut)
  );

  mul_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobes        (strobes),
    .multiplicandIn (multiplicandIn),
    .multiplierIn   (multiplierIn),
    .productOut     (productOut)
  );
endmodule

// File: tb/shift_add_mul_bench.sv
`timescale 1ns/1ps
module shift_add_mul_bench;
  localparam int W = 32;
  localparam int LAT = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startIn = 1'b0;
  logic [W-1:0]  mcand = '0;
  logic [W-1:0]  mplier = '0;
  logic          busyOut, doneOut;
  logic [2*W-1:0] productOut;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  shift_add_mul #(.WIDTH(W)) u_shift_add_mul (
    .clk(clk), .rstN(rstN), .startIn(startIn),
    .multiplicandIn(mcand), .multiplierIn(mplier),
    .busyOut(busyOut), .doneOut(doneOut), .productOut(productOut)
  );

  // {multiplicand, multiplier}
  localparam logic [63:0] VEC [8] = '{
    {32'd2,          32'd11},
    {32'd12345,      32'd6789},
    {32'hFFFFFFFF,   32'd1},
    {32'h80000000,   32'h80000000},
    {32'hDEADBEEF,   32'hCAFEF00D},
    {32'h7FFFFFFF,   32'hFFFFFFFF},
    {32'h00010001,   32'hAAAA5555},
    {32'hF0F0F0F0,   32'h0F0F0F0F}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive start at negedge; returns after the accepting edge, at the next negedge
  task automatic launch(input logic [W-1:0] a, input logic [W-1:0] b);
    startIn = 1'b1; mcand = a; mplier = b;
    @(posedge clk); @(negedge clk);
    startIn = 1'b0;
  endtask

  // counts edges until done; caller is at negedge after accepting edge
  task automatic waitDone(output int edges);
    edges = 0;
    for (int k = 1; k <= LAT + 8; k++) begin
      @(posedge clk); @(negedge clk);
      if (doneOut) begin edges = k; break; end
      if (!busyOut) begin edges = -k; break; end
    end
  endtask

  task automatic runOne(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    int e;
    logic [63:0] exp;
    exp = 64'(a) * 64'(b);
    launch(a, b);
    check(busyOut == 1'b1, {"R2 busy ", tag}, 64'(busyOut), 64'd1);
    check(productOut == {32'd0, b}, {"R2 load ", tag}, productOut, {32'd0, b});
    waitDone(e);
    check(e == LAT, {"R4 latency ", tag}, 64'(e), 64'(LAT));
    check(productOut == exp, {"R3 product ", tag}, productOut, exp);
    check(!busyOut, {"R5 busy low at done ", tag}, 64'(busyOut), 64'd0);
  endtask

  initial begin : watchdog
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (finished) disable watchdog;
    end
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int e;
    logic [63:0] exp;
    logic [63:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busyOut && !doneOut, "R1 flags", {62'd0, busyOut, doneOut}, 64'd0);
    check(productOut == '0, "R1 product", productOut, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      runOne(VEC[v][63:32], VEC[v][31:0], $sformatf("vec%0d", v));
      @(negedge clk);
    end

    // R9 corner operands
    runOne(32'd0, 32'hFFFFFFFF, "R9 zero mcand");
    runOne(32'hFFFFFFFF, 32'd0, "R9 zero mplier");
    runOne(32'hFFFFFFFF, 32'hFFFFFFFF, "R9 all ones");
    check(productOut == 64'hFFFFFFFE00000001, "R9 all-ones value", productOut, 64'hFFFFFFFE00000001);

    // R5 done is a single pulse, R7 hold afterwards
    held = productOut;
    @(posedge clk); @(negedge clk);
    check(!doneOut, "R5 done one cycle", 64'(doneOut), 64'd0);
    repeat (5) @(negedge clk);
    check(productOut == held && !doneOut && !busyOut, "R7 hold", productOut, held);

    // R6 start and operand changes ignored while busy
    exp = 64'(32'h12345678) * 64'(32'h9ABCDEF1);
    launch(32'h12345678, 32'h9ABCDEF1);
    repeat (9) begin @(posedge clk); @(negedge clk); end
    startIn = 1'b1; mcand = 32'h11111111; mplier = 32'h22222222;
    repeat (3) begin @(posedge clk); @(negedge clk); end
    startIn = 1'b0;
    e = 12;
    for (int k = 13; k <= LAT + 8; k++) begin
      @(posedge clk); @(negedge clk);
      if (doneOut) begin e = k; break; end
    end
    check(e == LAT, "R6 latency unchanged", 64'(e), 64'(LAT));
    check(productOut == exp, "R6 product unchanged", productOut, exp);

    // R8 restart in the done cycle
    exp = 64'(32'hA5A5A5A5) * 64'(32'h5A5A5A5A);
    launch(32'hA5A5A5A5, 32'h5A5A5A5A);
    check(busyOut && productOut == {32'd0, 32'h5A5A5A5A}, "R8 reload in done cycle",
          productOut, {32'd0, 32'h5A5A5A5A});
    waitDone(e);
    check(e == LAT, "R8 latency", 64'(e), 64'(LAT));
    check(productOut == exp, "R8 product", productOut, exp);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule